// File: doc/BRIEF.md
# FP Compare Condition Queue

This block maintains the compare-result fields of a 32-bit floating-point status word. Each compare arrives as a relation code from an external comparator, a 5-bit condition selector and a 3-bit target index. The block picks the one-bit outcome from the selector according to the relation. It then either deposits that outcome into one addressed condition-array bit (nonzero target) or pushes it through a queue. In the queued case the main condition bit enters the head of a ten-deep history and the new outcome takes its place. The block also reports whether the last applied compare was a signaling or a quiet compare.

Requests pass through two registered stages. A decode stage holds a small state machine. Its states are `ST_IDLE` (nothing to apply), `ST_LOAD` (whole-word write), `ST_TARGET` (addressed write) and `ST_QUEUE` (queued push). On every cycle it enters the state named by the request sampled at that edge, and it returns to `ST_IDLE` when no request is present. An update stage then applies the captured action to the status register on the next edge. A whole-word load port lets the surrounding logic set the status word, for example after a state restore.

Top module: `fpcq_top`

## Requirements
- R1: The outcome bit is taken from `cond_sel` by relation code: 0 (greater) uses bit 4, 1 (less) uses bit 3, 2 (equal) uses bit 2, 3 (unordered) uses bit 1; all four codes are legal.
- R2: `signaling` shows `cond_sel[0]` of the most recently applied compare (1 = signaling, 0 = quiet) and keeps its value across loads and idle cycles.
- R3: A compare with target index y in 1..7 writes the outcome into status bit 22−y only (y=1 gives bit 21, y=7 gives bit 15).
- R4: A compare with y = 0 moves bits 21:12 down one place into bits 20:11, copies the old bit 26 into bit 21, and writes the outcome into bit 26.
- R5: Every status bit not named in R3 or R4 for the applied operation keeps its value, including bit 26 on a targeted compare.
- R6: `ld_valid` writes `ld_word` into the whole status word; when it is high together with `cmp_valid`, the load wins and the compare is dropped.
- R7: A request sampled at clock edge k is visible on `status_word` after edge k+1; when no request is sampled, the word holds.
- R8: After reset, `status_word` is 0 and `signaling` is 0.
- R9: Compares on consecutive cycles are each applied, in arrival order, with each one acting on the word left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Whole-word load strobe |
| ld_word | input | 32 | Value to load into the status word |
| cmp_valid | input | 1 | Compare result strobe |
| relation | input | 2 | Relation code: 0 greater, 1 less, 2 equal, 3 unordered |
| cond_sel | input | 5 | Condition selector; bit 0 selects signaling mode |
| target | input | 3 | 0 = queued compare, 1..7 = targeted bit |
| status_word | output | 32 | Current status word |
| signaling | output | 1 | Mode of the last applied compare |

## Verification
The hardest situation to reach is a long run of queued compares that carry a distinctive history through all ten queue slots. The bench also has to observe the oldest entry falling out at bit 11 while targeted writes into bits 21..15 land in the middle of that history. The stimulus first loads a known word. It then issues back-to-back random mixes of queued and targeted compares, with occasional loads colliding with compares, and compares the whole word each cycle against a bench model. Directed runs cover the two ends of the target range, every relation code, and idle stretches.

// File: rtl/fpcq_pkg.sv
package fpcq_pkg;
    parameter int WORD_W   = 32;
    parameter int MAIN_BIT = 26;
    parameter int Q_HEAD   = 21;
    parameter int Q_LEN    = 10;
    parameter int SEL_W    = 5;
    parameter int TGT_W    = 3;
    parameter int REL_W    = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_TARGET = 2'd2,
        ST_QUEUE  = 2'd3
    } act_e;
endpackage

// File: rtl/fpcq_outcome_sel.sv
module fpcq_outcome_sel
    import fpcq_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int RW = REL_W
) (
    input  logic [RW-1:0] relation,
    input  logic [SW-1:1] sel_bits,
    output logic          outcome
);
    // relation 0..3 picks selector bit 4..1
    always_comb begin
        unique case (relation)
            2'd0:    outcome = sel_bits[4];
            2'd1:    outcome = sel_bits[3];
            2'd2:    outcome = sel_bits[2];
            default: outcome = sel_bits[1];
        endcase
    end
endmodule

// File: rtl/fpcq_decode.sv
module fpcq_decode
    import fpcq_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int SW = SEL_W,
    parameter int TW = TGT_W,
    parameter int RW = REL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [W-1:0]  ld_word,
    input  logic          cmp_valid,
    input  logic [RW-1:0] relation,
    input  logic [SW-1:0] cond_sel,
    input  logic [TW-1:0] target,
    output act_e          act,
    output logic          act_out,
    output logic          act_sig,
    output logic [TW-1:0] act_tgt,
    output logic [W-1:0]  act_word
);
    act_e state_q, state_d;
    logic outc;

    fpcq_outcome_sel #(.SW(SW), .RW(RW)) u_sel (
        .relation (relation),
        .sel_bits (cond_sel[SW-1:1]),
        .outcome  (outc)
    );

    // next-state: load beats compare
    always_comb begin
        if (ld_valid)
            state_d = ST_LOAD;
        else if (cmp_valid && (target != '0))
            state_d = ST_TARGET;
        else if (cmp_valid)
            state_d = ST_QUEUE;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // captured fields for the update stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_out  <= 1'b0;
            act_sig  <= 1'b0;
            act_tgt  <= '0;
            act_word <= '0;
        end else begin
            unique case (state_d)
                ST_LOAD: begin
                    act_word <= ld_word;
                end
                ST_TARGET, ST_QUEUE: begin
                    act_out <= outc;
                    act_sig <= cond_sel[0];
                    act_tgt <= target;
                end
                default: begin
                    act_out <= act_out;
                end
            endcase
        end
    end

    assign act = state_q;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (state_q == ST_LOAD)); // R6
    AST_CMP_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !ld_valid) |=> (state_q == ST_TARGET || state_q == ST_QUEUE)); // R9
    AST_IDLE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_valid && !ld_valid) |=> (state_q == ST_IDLE)); // R7
endmodule

// File: rtl/fpcq_status_upd.sv
module fpcq_status_upd
    import fpcq_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int TW    = TGT_W,
    parameter int MAIN  = MAIN_BIT,
    parameter int QHEAD = Q_HEAD,
    parameter int QLEN  = Q_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_e          act,
    input  logic          act_out,
    input  logic          act_sig,
    input  logic [TW-1:0] act_tgt,
    input  logic [W-1:0]  act_word,
    output logic [W-1:0]  status,
    output logic          sig_mode
);
    localparam int QLOW     = QHEAD - QLEN;   // lowest bit the queue shifts into
    localparam int TGT_BASE = QHEAD + 1;      // y maps to bit TGT_BASE - y
    localparam int PW       = $clog2(W) + 1;

    logic [W-1:0]  st_q, st_d;
    logic [PW-1:0] tgt_pos;

    assign tgt_pos = PW'(TGT_BASE) - PW'(act_tgt);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic q_val;
        if (b == MAIN) begin : g_main
            assign q_val = act_out;
        end else if (b == QHEAD) begin : g_head
            assign q_val = st_q[MAIN];
        end else if (b >= QLOW && b < QHEAD) begin : g_shift
            assign q_val = st_q[b+1];
        end else begin : g_keep
            assign q_val = st_q[b];
        end

        always_comb begin
            unique case (act)
                ST_LOAD:   st_d[b] = act_word[b];
                ST_TARGET: st_d[b] = (tgt_pos == PW'(b)) ? act_out : st_q[b];
                ST_QUEUE:  st_d[b] = q_val;
                default:   st_d[b] = st_q[b];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            sig_mode <= 1'b0;
        end else begin
            st_q <= st_d;
            if (act == ST_TARGET || act == ST_QUEUE)
                sig_mode <= act_sig;
        end
    end

    assign status = st_q;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ST_IDLE) |=> $stable(st_q)); // R7
    AST_TGT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ST_TARGET) |=> ($countones(st_q ^ $past(st_q)) <= 1)); // R3
    AST_TGT_MAIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ST_TARGET) |=> $stable(st_q[MAIN])); // R5
    AST_QUEUE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ST_QUEUE) |=> (st_q[QHEAD] == $past(st_q[MAIN]))); // R4
    AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ST_QUEUE) |=> (st_q[QHEAD-1:QLOW] == $past(st_q[QHEAD:QLOW+1]))); // R4
    AST_SIG_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ST_QUEUE || act == ST_TARGET) |=> (sig_mode == $past(act_sig))); // R2
    AST_SIG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ST_LOAD || act == ST_IDLE) |=> $stable(sig_mode)); // R2
endmodule

// File: rtl/fpcq_top.sv
module fpcq_top
    import fpcq_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int SW    = SEL_W,
    parameter int TW    = TGT_W,
    parameter int RW    = REL_W,
    parameter int MAIN  = MAIN_BIT,
    parameter int QHEAD = Q_HEAD,
    parameter int QLEN  = Q_LEN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic [W-1:0]  ld_word,
    input  logic          cmp_valid,
    input  logic [RW-1:0] relation,
    input  logic [SW-1:0] cond_sel,
    input  logic [TW-1:0] target,
    output logic [W-1:0]  status_word,
    output logic          signaling
);
    act_e          act;
    logic          act_out;
    logic          act_sig;
    logic [TW-1:0] act_tgt;
    logic [W-1:0]  act_word;

    fpcq_decode #(.W(W), .SW(SW), .TW(TW), .RW(RW)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .ld_word   (ld_word),
        .cmp_valid (cmp_valid),
        .relation  (relation),
        .cond_sel  (cond_sel),
        .target    (target),
        .act       (act),
        .act_out   (act_out),
        .act_sig   (act_sig),
        .act_tgt   (act_tgt),
        .act_word  (act_word)
    );

    fpcq_status_upd #(.W(W), .TW(TW), .MAIN(MAIN), .QHEAD(QHEAD), .QLEN(QLEN)) u_upd (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .act_out  (act_out),
        .act_sig  (act_sig),
        .act_tgt  (act_tgt),
        .act_word (act_word),
        .status   (status_word),
        .sig_mode (signaling)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (status_word == '0 && signaling == 1'b0)); // R8
endmodule

// File: tb/fpcq_top_test.sv
`timescale 1ns/1ps
module fpcq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_word = '0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  relation = '0;
    logic [4:0]  cond_sel = '0;
    logic [2:0]  target = '0;
    logic [31:0] status_word;
    logic        signaling;

    int compared = 0;
    int mismatched = 0;

    // model state and one pending request (two-stage latency)
    logic [31:0] m_st = '0;
    logic        m_sig = 1'b0;
    logic        p_ld = 1'b0, p_cmp = 1'b0;
    logic [31:0] p_word = '0;
    logic [1:0]  p_rel = '0;
    logic [4:0]  p_sel = '0;
    logic [2:0]  p_tgt = '0;

    always #2 clk = ~clk;

    fpcq_top uut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_word(ld_word),
        .cmp_valid(cmp_valid), .relation(relation), .cond_sel(cond_sel),
        .target(target), .status_word(status_word), .signaling(signaling)
    );

    function automatic logic pick(input logic [1:0] rel, input logic [4:0] sel);
        return sel[4 - int'(rel)];
    endfunction

    function automatic logic [31:0] apply_cmp(input logic [31:0] s, input logic o,
                                              input logic [2:0] y);
        logic [31:0] n = s;
        if (y != 0) begin
            n[22 - int'(y)] = o;
        end else begin
            for (int i = 11; i <= 20; i++) n[i] = s[i+1];
            n[21] = s[26];
            n[26] = o;
        end
        return n;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic l, input logic [31:0] w, input logic c,
                        input logic [1:0] r, input logic [4:0] s, input logic [2:0] y,
                        input string req);
        ld_valid = l; ld_word = w; cmp_valid = c; relation = r; cond_sel = s; target = y;
        @(posedge clk);
        @(negedge clk);
        if (p_ld) m_st = p_word;
        else if (p_cmp) begin
            m_st  = apply_cmp(m_st, pick(p_rel, p_sel), p_tgt);
            m_sig = p_sel[0];
        end
        p_ld = l; p_cmp = c; p_word = w; p_rel = r; p_sel = s; p_tgt = y;
        chk(req, status_word, m_st);
        chk({req, " signaling"}, {31'd0, signaling}, {31'd0, m_sig});
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, '0, '0, '0, req);
    endtask

    initial begin
        #400000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R8 reset", status_word, 32'd0);
        chk("R8 reset signaling", {31'd0, signaling}, 32'd0);
        rst_n = 1'b1;

        // R7: load visible after second edge, then holds
        ld_valid = 1'b1; ld_word = 32'hA5A5_5A5A;
        @(posedge clk); @(negedge clk);
        ld_valid = 1'b0;
        chk("R7 not yet", status_word, 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R7 load visible", status_word, 32'hA5A5_5A5A);
        m_st = 32'hA5A5_5A5A;
        idle(4, "R7 hold");

        // R1 + R3: each relation into targeted bits, both extremes of y
        for (int rel = 0; rel < 4; rel++) begin
            step(1'b0, '0, 1'b1, 2'(rel), 5'b11111 ^ (5'b10000 >> rel), 3'd1, "R1 R3 y1 zero");
            step(1'b0, '0, 1'b1, 2'(rel), 5'b00000 | (5'b10000 >> rel), 3'd7, "R1 R3 y7 one");
        end
        idle(1, "R3 R5 settle");

        // R4 + R5: queue pushes from a known word
        step(1'b1, 32'hFC00_0000 | 32'h0440_0801, 1'b0, '0, '0, '0, "R6 load");
        for (int i = 0; i < 12; i++)
            step(1'b0, '0, 1'b1, 2'(i % 4), 5'(i * 7 + 3), 3'd0, "R4 R5 queue");
        idle(1, "R4 settle");

        // R6: load collides with compare
        step(1'b1, 32'h1234_5678, 1'b1, 2'd0, 5'b10001, 3'd0, "R6 collide");
        idle(2, "R6 load wins");

        // R2 + R9: random back-to-back mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] rw = $urandom;
            logic l = ($urandom % 16) == 0;
            logic c = ($urandom % 8) != 0;
            logic [2:0] y = (($urandom % 2) == 0) ? 3'd0 : 3'($urandom);
            step(l, rw, c, 2'($urandom), 5'($urandom), y, "R2 R9 random");
        end
        idle(2, "R9 drain");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule